// File: doc/BRIEF.md
# MMU Fault Status Capture

This block holds the diagnostic state that fault handling software inspects after an address translation fault. For a data-side fault it records the faulting virtual address, a packed status word, and a formatted page-table-entry address. The status word combines the opcode, the register field and the fault flags of the instruction. The formatted address is the data page-table base combined with the virtual page number of the faulting address. A data fault raised by a page-table-entry fetch or by a prefetch leaves all three data-side registers untouched.

For an instruction-side fault it records the faulting PC as a tag, together with an instruction-side formatted address built from the instruction page-table base. Software can write both page-table base registers. A combinational read port returns any register chosen by a 3-bit address, and reading has no side effects. Registers never lock: every qualifying fault overwrites what an earlier fault left behind.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, all seven registers read as zero.
- R2: A data fault strobe without either qualifier loads the fault address register (read address 0) with the 43-bit faulting address, zero-extended to 64 bits, at the clock edge where the strobe is high.
- R3: On that same edge the status register (read address 1) loads the opcode into bits 16:11, the register field into bits 10:6 and the fault flags into bits 5:0. Bits 63:17 read as zero.
- R4: On that same edge the data formatted-address register (read address 2) loads the data page-table base OR'd with the virtual page number (address bits 42:13) shifted left by 3.
- R5: A data fault whose page-table-fetch or prefetch qualifier is high leaves read addresses 0, 1 and 2 unchanged.
- R6: An instruction fault strobe loads the tag register (read address 3) with the zero-extended PC. It also loads the instruction formatted-address register (read address 4) with the instruction page-table base OR'd with PC bits 42:13 shifted left by 3.
- R7: A write with side select 0 loads the data page-table base (read address 5). A write with side select 1 loads the instruction page-table base (read address 6).
- R8: Every qualifying fault overwrites the earlier capture, and repeated reads return the same value.
- R9: When a base-register write and a fault share an edge, the formatted address uses the base value from before that write.
- R10: Read address 7 returns zero.
- R11: Data and instruction faults on the same edge are both captured, and an instruction fault leaves the data-side registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dfault_i | input | 1 | Data fault strobe |
| dfault_va_i | input | 43 | Faulting data virtual address |
| dfault_opc_i | input | 6 | Opcode of faulting instruction |
| dfault_ra_i | input | 5 | Register field of faulting instruction |
| dfault_flags_i | input | 6 | Fault flags |
| dfault_ptefetch_i | input | 1 | Request is a page-table-entry fetch |
| dfault_prefetch_i | input | 1 | Request is a prefetch |
| ifault_i | input | 1 | Instruction fault strobe |
| ifault_pc_i | input | 43 | Faulting PC |
| ptb_we_i | input | 1 | Page-table base write enable |
| ptb_sel_i | input | 1 | 0 data side, 1 instruction side |
| ptb_wdata_i | input | 64 | Page-table base write data |
| rd_addr_i | input | 3 | Register read select |
| rd_data_o | output | 64 | Selected register value |

## Verification
The checker tests the following on every cycle:
- Loading of the fault address and tag one edge after a strobe.
- Holding of the data-side registers under a suppressed fault.
- Zero upper status bits.
- Base-register loads.
- The zero value returned at read address 7.

The formatted addresses, the field packing and the overwrite order appear only in bench scenarios. The same holds for the base value used when a write coincides with a fault and for data and instruction faults arriving together. In each case the bench reads the values back through the port and compares them with values computed from the requirements.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;
  localparam int unsigned VA_W      = 43;
  localparam int unsigned PAGE_BITS = 13;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned RA_W      = 5;
  localparam int unsigned FLG_W     = 6;
  localparam int unsigned PTE_SHIFT = 3;
  localparam int unsigned RD_AW     = 3;

  typedef enum logic [RD_AW-1:0] {
    RD_FVA   = 3'd0,
    RD_STAT  = 3'd1,
    RD_DFORM = 3'd2,
    RD_ITAG  = 3'd3,
    RD_IFORM = 3'd4,
    RD_DPTB  = 3'd5,
    RD_IPTB  = 3'd6,
    RD_NONE  = 3'd7
  } rd_sel_e;
endpackage

// File: rtl/mmu_ptb_regs.sv
module mmu_ptb_regs #(
  parameter int unsigned REG_W   = 64,
  parameter int unsigned N_SIDES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     sel_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [N_SIDES*REG_W-1:0] ptb_o
);
  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic [REG_W-1:0] ptb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       ptb_q <= '0;
      else if (we_i && (sel_i == s[0]))  ptb_q <= wdata_i;
    end
    assign ptb_o[s*REG_W +: REG_W] = ptb_q;
  end
endmodule

// File: rtl/mmu_dside_capture.sv
module mmu_dside_capture #(
  parameter int unsigned VA_W      = 43,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned REG_W     = 64,
  parameter int unsigned OPC_W     = 6,
  parameter int unsigned RA_W      = 5,
  parameter int unsigned FLG_W     = 6,
  parameter int unsigned PTE_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [OPC_W-1:0] opc_i,
  input  logic [RA_W-1:0]  ra_i,
  input  logic [FLG_W-1:0] flags_i,
  input  logic             ptefetch_i,
  input  logic             prefetch_i,
  input  logic [REG_W-1:0] ptb_i,
  output logic [REG_W-1:0] fva_o,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] form_o
);
  localparam int unsigned VPN_W  = VA_W - PAGE_BITS;
  localparam int unsigned STAT_W = OPC_W + RA_W + FLG_W;

  logic             capture;
  logic [REG_W-1:0] vpn_ext;

  // page-table fetches and prefetches must not disturb the handler's view
  assign capture = fault_i && !ptefetch_i && !prefetch_i;
  assign vpn_ext = {{(REG_W-VPN_W){1'b0}}, va_i[VA_W-1:PAGE_BITS]} << PTE_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fva_o  <= '0;
      stat_o <= '0;
      form_o <= '0;
    end else if (capture) begin
      fva_o  <= {{(REG_W-VA_W){1'b0}}, va_i};
      stat_o <= {{(REG_W-STAT_W){1'b0}}, opc_i, ra_i, flags_i};
      form_o <= ptb_i | vpn_ext;
    end
  end
endmodule

// File: rtl/mmu_iside_capture.sv
module mmu_iside_capture #(
  parameter int unsigned VA_W      = 43,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned REG_W     = 64,
  parameter int unsigned PTE_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [VA_W-1:0]  pc_i,
  input  logic [REG_W-1:0] ptb_i,
  output logic [REG_W-1:0] tag_o,
  output logic [REG_W-1:0] form_o
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;

  logic [REG_W-1:0] vpn_ext;
  assign vpn_ext = {{(REG_W-VPN_W){1'b0}}, pc_i[VA_W-1:PAGE_BITS]} << PTE_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      form_o <= '0;
    end else if (fault_i) begin
      tag_o  <= {{(REG_W-VA_W){1'b0}}, pc_i};
      form_o <= ptb_i | vpn_ext;
    end
  end
endmodule

// File: rtl/mmu_fault_rdmux.sv
module mmu_fault_rdmux
  import mmu_fault_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic [RD_AW-1:0] addr_i,
  input  logic [REG_W-1:0] fva_i,
  input  logic [REG_W-1:0] stat_i,
  input  logic [REG_W-1:0] dform_i,
  input  logic [REG_W-1:0] itag_i,
  input  logic [REG_W-1:0] iform_i,
  input  logic [REG_W-1:0] dptb_i,
  input  logic [REG_W-1:0] iptb_i,
  output logic [REG_W-1:0] data_o
);
  always_comb begin
    unique case (rd_sel_e'(addr_i))
      RD_FVA:   data_o = fva_i;
      RD_STAT:  data_o = stat_i;
      RD_DFORM: data_o = dform_i;
      RD_ITAG:  data_o = itag_i;
      RD_IFORM: data_o = iform_i;
      RD_DPTB:  data_o = dptb_i;
      RD_IPTB:  data_o = iptb_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_fault_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dfault_i,
  input  logic [VA_W-1:0]  dfault_va_i,
  input  logic [OPC_W-1:0] dfault_opc_i,
  input  logic [RA_W-1:0]  dfault_ra_i,
  input  logic [FLG_W-1:0] dfault_flags_i,
  input  logic             dfault_ptefetch_i,
  input  logic             dfault_prefetch_i,
  input  logic             ifault_i,
  input  logic [VA_W-1:0]  ifault_pc_i,
  input  logic             ptb_we_i,
  input  logic             ptb_sel_i,
  input  logic [REG_W-1:0] ptb_wdata_i,
  input  logic [RD_AW-1:0] rd_addr_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [2*REG_W-1:0] ptb_all;
  logic [REG_W-1:0]   dptb_q, iptb_q;
  logic [REG_W-1:0]   fva_q, stat_q, dform_q, itag_q, iform_q;

  mmu_ptb_regs #(.REG_W(REG_W), .N_SIDES(2)) i_ptb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ptb_we_i),
    .sel_i   (ptb_sel_i),
    .wdata_i (ptb_wdata_i),
    .ptb_o   (ptb_all)
  );
  assign dptb_q = ptb_all[0 +: REG_W];
  assign iptb_q = ptb_all[REG_W +: REG_W];

  mmu_dside_capture #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .REG_W(REG_W), .OPC_W(OPC_W),
    .RA_W(RA_W), .FLG_W(FLG_W), .PTE_SHIFT(PTE_SHIFT)
  ) i_dside (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_i    (dfault_i),
    .va_i       (dfault_va_i),
    .opc_i      (dfault_opc_i),
    .ra_i       (dfault_ra_i),
    .flags_i    (dfault_flags_i),
    .ptefetch_i (dfault_ptefetch_i),
    .prefetch_i (dfault_prefetch_i),
    .ptb_i      (dptb_q),
    .fva_o      (fva_q),
    .stat_o     (stat_q),
    .form_o     (dform_q)
  );

  mmu_iside_capture #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .REG_W(REG_W), .PTE_SHIFT(PTE_SHIFT)
  ) i_iside (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (ifault_i),
    .pc_i    (ifault_pc_i),
    .ptb_i   (iptb_q),
    .tag_o   (itag_q),
    .form_o  (iform_q)
  );

  mmu_fault_rdmux #(.REG_W(REG_W)) i_rdmux (
    .addr_i  (rd_addr_i),
    .fva_i   (fva_q),
    .stat_i  (stat_q),
    .dform_i (dform_q),
    .itag_i  (itag_q),
    .iform_i (iform_q),
    .dptb_i  (dptb_q),
    .iptb_i  (iptb_q),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk
  import mmu_fault_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dfault_i,
  input logic [VA_W-1:0]  dfault_va_i,
  input logic             dfault_ptefetch_i,
  input logic             dfault_prefetch_i,
  input logic             ifault_i,
  input logic [VA_W-1:0]  ifault_pc_i,
  input logic             ptb_we_i,
  input logic             ptb_sel_i,
  input logic [REG_W-1:0] ptb_wdata_i,
  input logic [RD_AW-1:0] rd_addr_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [REG_W-1:0] fva_q,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] dform_q,
  input logic [REG_W-1:0] itag_q,
  input logic [REG_W-1:0] dptb_q,
  input logic [REG_W-1:0] iptb_q
);
  localparam int unsigned STAT_W = OPC_W + RA_W + FLG_W;

  a_r2_fva_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dfault_i && !dfault_ptefetch_i && !dfault_prefetch_i)
    |=> fva_q == {{(REG_W-VA_W){1'b0}}, $past(dfault_va_i)});

  a_r3_stat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[REG_W-1:STAT_W] == '0);

  a_r5_suppress_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dfault_i && (dfault_ptefetch_i || dfault_prefetch_i))
    |=> ($stable(fva_q) && $stable(stat_q) && $stable(dform_q)));

  a_r6_tag_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifault_i |=> itag_q == {{(REG_W-VA_W){1'b0}}, $past(ifault_pc_i)});

  a_r7_dptb_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptb_we_i && !ptb_sel_i) |=> (dptb_q == $past(ptb_wdata_i)));

  a_r7_iptb_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptb_we_i && ptb_sel_i) |=> (iptb_q == $past(ptb_wdata_i)));

  a_r10_unused_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == RD_NONE) |-> (rd_data_o == '0));

  a_r11_ifault_keeps_dside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifault_i && !dfault_i) |=> ($stable(fva_q) && $stable(dform_q)));
endmodule

bind mmu_fault_capture mmu_fault_capture_chk i_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .dfault_i          (dfault_i),
  .dfault_va_i       (dfault_va_i),
  .dfault_ptefetch_i (dfault_ptefetch_i),
  .dfault_prefetch_i (dfault_prefetch_i),
  .ifault_i          (ifault_i),
  .ifault_pc_i       (ifault_pc_i),
  .ptb_we_i          (ptb_we_i),
  .ptb_sel_i         (ptb_sel_i),
  .ptb_wdata_i       (ptb_wdata_i),
  .rd_addr_i         (rd_addr_i),
  .rd_data_o         (rd_data_o),
  .fva_q             (fva_q),
  .stat_q            (stat_q),
  .dform_q           (dform_q),
  .itag_q            (itag_q),
  .dptb_q            (dptb_q),
  .iptb_q            (iptb_q)
);

// File: tb/test_mmu_fault_capture.sv
module test_mmu_fault_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dfault_i = 1'b0;
  logic [42:0] dfault_va_i = '0;
  logic [5:0]  dfault_opc_i = '0;
  logic [4:0]  dfault_ra_i = '0;
  logic [5:0]  dfault_flags_i = '0;
  logic        dfault_ptefetch_i = 1'b0;
  logic        dfault_prefetch_i = 1'b0;
  logic        ifault_i = 1'b0;
  logic [42:0] ifault_pc_i = '0;
  logic        ptb_we_i = 1'b0;
  logic        ptb_sel_i = 1'b0;
  logic [63:0] ptb_wdata_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  mmu_fault_capture i_mmu_fault_capture (.*);

  typedef struct {
    logic [2:0]  addr;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [63:0] m_fva, m_stat, m_dform, m_itag, m_iform, m_dptb, m_iptb;

  function automatic logic [63:0] fmt(input logic [63:0] ptb, input logic [42:0] va);
    return ptb | ({34'b0, va[42:13]} << 3);
  endfunction

  // monitor: compare each queued expectation while its address is applied
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rd_data_o !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.addr, rd_data_o, it.exp);
        end
      end
    end
  end

  task automatic rd_chk(input logic [2:0] a, input logic [63:0] e, input string r);
    @(negedge clk_i);
    rd_addr_i = a;
    sb_q.push_back('{a, e, r});
  endtask

  task automatic check_all(input string r);
    rd_chk(3'd0, m_fva, r);
    rd_chk(3'd1, m_stat, r);
    rd_chk(3'd2, m_dform, r);
    rd_chk(3'd3, m_itag, r);
    rd_chk(3'd4, m_iform, r);
    rd_chk(3'd5, m_dptb, r);
    rd_chk(3'd6, m_iptb, r);
    rd_chk(3'd7, 64'd0, r);
  endtask

  task automatic ptb_wr(input bit side, input logic [63:0] d);
    @(negedge clk_i);
    ptb_we_i = 1'b1; ptb_sel_i = side; ptb_wdata_i = d;
    @(negedge clk_i);
    ptb_we_i = 1'b0;
    if (side) m_iptb = d; else m_dptb = d;
  endtask

  task automatic dfault(input logic [42:0] va, input logic [5:0] opc, input logic [4:0] ra,
                        input logic [5:0] fl, input bit pte, input bit pf);
    @(negedge clk_i);
    dfault_i = 1'b1; dfault_va_i = va; dfault_opc_i = opc; dfault_ra_i = ra;
    dfault_flags_i = fl; dfault_ptefetch_i = pte; dfault_prefetch_i = pf;
    @(negedge clk_i);
    dfault_i = 1'b0; dfault_ptefetch_i = 1'b0; dfault_prefetch_i = 1'b0;
    if (!pte && !pf) begin
      m_fva   = {21'b0, va};
      m_stat  = {47'b0, opc, ra, fl};
      m_dform = fmt(m_dptb, va);
    end
  endtask

  task automatic ifault(input logic [42:0] pc);
    @(negedge clk_i);
    ifault_i = 1'b1; ifault_pc_i = pc;
    @(negedge clk_i);
    ifault_i = 1'b0;
    m_itag  = {21'b0, pc};
    m_iform = fmt(m_iptb, pc);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_fva = '0; m_stat = '0; m_dform = '0; m_itag = '0;
    m_iform = '0; m_dptb = '0; m_iptb = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_all("R1 reset");

    ptb_wr(1'b0, 64'h0000_0400_0000_0000);
    ptb_wr(1'b1, 64'h0000_0800_0000_0000);
    rd_chk(3'd5, m_dptb, "R7 dptb");
    rd_chk(3'd6, m_iptb, "R7 iptb");

    dfault(43'h5AB_CDEF_1234, 6'h2A, 5'h15, 6'h33, 1'b0, 1'b0);
    rd_chk(3'd0, m_fva, "R2 fva");
    rd_chk(3'd1, 64'h0000_0000_0001_5573, "R3 stat packing");
    rd_chk(3'd2, m_dform, "R4 dform");

    dfault(43'h7FF_FFFF_FFFF, 6'h3F, 5'h1F, 6'h3F, 1'b1, 1'b0);
    check_all("R5 ptefetch suppress");
    dfault(43'h123_4567_89AB, 6'h01, 5'h02, 6'h03, 1'b0, 1'b1);
    check_all("R5 prefetch suppress");
    dfault(43'h000_0000_2000, 6'h05, 5'h06, 6'h07, 1'b1, 1'b1);
    check_all("R5 both qualifiers");

    ifault(43'h3C0_FFEE_5678);
    check_all("R6 ifault and R11 data regs kept");

    dfault(43'h7FF_FFFF_E000, 6'h3F, 5'h00, 6'h00, 1'b0, 1'b0);
    rd_chk(3'd1, 64'h0000_0000_0001_F800, "R3 opcode only");
    rd_chk(3'd0, m_fva, "R8 overwrite");
    rd_chk(3'd0, m_fva, "R8 reread");
    rd_chk(3'd2, m_dform, "R8 overwrite dform");

    dfault(43'h000_0000_1FFF, 6'h00, 5'h1F, 6'h00, 1'b0, 1'b0);
    rd_chk(3'd1, 64'h0000_0000_0000_07C0, "R3 reg only");
    rd_chk(3'd2, m_dptb, "R4 vpn zero");

    // base write coinciding with faults: old base must be used
    @(negedge clk_i);
    ptb_we_i = 1'b1; ptb_sel_i = 1'b0; ptb_wdata_i = 64'hF000_0000_0000_0000;
    dfault_i = 1'b1; dfault_va_i = 43'h100_0000_4000; dfault_opc_i = 6'h11;
    dfault_ra_i = 5'h3; dfault_flags_i = 6'h1;
    @(negedge clk_i);
    ptb_we_i = 1'b0; dfault_i = 1'b0;
    m_fva = {21'b0, 43'h100_0000_4000};
    m_stat = {47'b0, 6'h11, 5'h3, 6'h1};
    m_dform = fmt(m_dptb, 43'h100_0000_4000);
    m_dptb = 64'hF000_0000_0000_0000;
    rd_chk(3'd2, m_dform, "R9 old dptb used");
    rd_chk(3'd5, m_dptb, "R9 dptb updated");

    @(negedge clk_i);
    ptb_we_i = 1'b1; ptb_sel_i = 1'b1; ptb_wdata_i = 64'h0F00_0000_0000_0000;
    ifault_i = 1'b1; ifault_pc_i = 43'h0AA_AAAA_A000;
    @(negedge clk_i);
    ptb_we_i = 1'b0; ifault_i = 1'b0;
    m_itag = {21'b0, 43'h0AA_AAAA_A000};
    m_iform = fmt(m_iptb, 43'h0AA_AAAA_A000);
    m_iptb = 64'h0F00_0000_0000_0000;
    rd_chk(3'd4, m_iform, "R9 old iptb used");

    // simultaneous data and instruction faults
    @(negedge clk_i);
    dfault_i = 1'b1; dfault_va_i = 43'h2EE_1111_0000; dfault_opc_i = 6'h22;
    dfault_ra_i = 5'h0A; dfault_flags_i = 6'h2C;
    ifault_i = 1'b1; ifault_pc_i = 43'h155_2222_4000;
    @(negedge clk_i);
    dfault_i = 1'b0; ifault_i = 1'b0;
    m_fva = {21'b0, 43'h2EE_1111_0000};
    m_stat = {47'b0, 6'h22, 5'h0A, 6'h2C};
    m_dform = fmt(m_dptb, 43'h2EE_1111_0000);
    m_itag = {21'b0, 43'h155_2222_4000};
    m_iform = fmt(m_iptb, 43'h155_2222_4000);
    check_all("R11 simultaneous");
    rd_chk(3'd7, 64'd0, "R10 unused addr");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule